// File: doc/BRIEF.md
# Character ROM Bank Translator

This block sits between a video chip's 8 KB pattern-memory address space and a larger character ROM. That space is split into eight 1 KB windows. Each window is redirected to a 1 KB ROM page. The CPU loads sixteen byte-wide bank registers: eight carry the low bytes and eight carry the high bytes. The low and high byte of the same index form one 16-bit bank number. A 2-bit granularity field in a shared control register selects one of four schemes. The address space is served by one 8 KB bank, by two 4 KB banks, by four 2 KB banks, or by eight separate 1 KB banks.

For every video address the block returns, in the same cycle, a ROM page number and the untouched offset within the page. The page number is folded into the ROM's real size. That size is given as a page count on a configuration input. Register writes are synchronous and take effect from the cycle after the write edge.

Top module: `chr_bank_xlate`

## Requirements
- R1: After a synchronous reset, low register i holds i (for i = 0..7), every high register holds 0, and the granularity is 8 KB, so window k reads page k (before the fold of R8).
- R2: A write with wr_addr_i in 0x9000..0x9007 loads wr_data_i into low register wr_addr_i[2:0]. A write in 0xA000..0xA007 loads high register wr_addr_i[2:0]. Bank number i is high[i]*256 + low[i].
- R3: A write to 0xD000 sets the granularity to wr_data_i[4:3], with 0 = 8 KB, 1 = 4 KB, 2 = 2 KB and 3 = 1 KB. The other data bits have no effect.
- R4: In 8 KB mode, window k reads page bank0*8 + k.
- R5: In 4 KB mode, windows 0..3 read bank0*4 + k, and windows 4..7 read bank4*4 + (k-4).
- R6: In 2 KB mode, window k reads bank[2*floor(k/2)]*2 + (k mod 2).
- R7: In 1 KB mode, window k reads bank k.
- R8: The output page is the raw page modulo page_count_i. When page_count_i is 0, the output page is 0.
- R9: The window index is vaddr_i[12:10], and offset_o equals vaddr_i[9:0]. Outputs follow vaddr_i in the same cycle and reflect register writes from the cycle after the write edge.
- R10: Writes to any other address, and any cycle with wr_en_i low, leave all bank registers and the granularity unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | CPU register write strobe |
| wr_addr_i | input | 16 | CPU write address |
| wr_data_i | input | 8 | CPU write data |
| page_count_i | input | CNT_W | Number of 1 KB pages in the character ROM |
| vaddr_i | input | 13 | Video pattern-memory address |
| page_o | output | CNT_W | Selected 1 KB ROM page |
| offset_o | output | 10 | Byte offset within the page |

## Verification
Every window is swept under each of the four granularities, using one bank-register pattern. The low and high bytes differ per index and several high bytes are nonzero. A wrong source register, shift or in-half index therefore yields a different page. The page count is then varied: a large value leaves raw pages intact, small non-power-of-two values and 1 force the fold, and 0 checks the fallback. Near-miss addresses, a control write with stray bits set, and a suppressed strobe show whether decoding and the write enable keep the state apart.

// File: rtl/chr_xlate_pkg.sv
package chr_xlate_pkg;

    localparam int WIN_N  = 8;
    localparam int WIN_W  = 3;
    localparam int OFS_W  = 10;
    localparam int HALF_W = 8;
    localparam int BANK_W = 2 * HALF_W;
    localparam int RAW_W  = BANK_W + WIN_W;
    localparam int VA_W   = WIN_W + OFS_W;
    localparam int ADDR_W = 16;

    localparam logic [ADDR_W-1:0] LO_BASE   = 16'h9000;
    localparam logic [ADDR_W-1:0] HI_BASE   = 16'hA000;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 16'hD000;

    typedef enum logic [1:0] {
        GRAN_8K = 2'd0,
        GRAN_4K = 2'd1,
        GRAN_2K = 2'd2,
        GRAN_1K = 2'd3
    } gran_e;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } bank_reg_t;

    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic [OFS_W-1:0] ofs;
    } vaddr_t;

    // Window bits that choose the source register; the rest index inside the bank.
    function automatic logic [WIN_W-1:0] src_mask(gran_e g);
        case (g)
            GRAN_8K: return 3'b000;
            GRAN_4K: return 3'b100;
            GRAN_2K: return 3'b110;
            default: return 3'b111;
        endcase
    endfunction

    // Raw page: bank scaled by the bank size in pages, plus the index inside it.
    function automatic logic [RAW_W-1:0] scale(bank_reg_t b, gran_e g,
                                               logic [WIN_W-1:0] k);
        logic [1:0] sh;
        sh = 2'd3 - 2'(g);
        return (RAW_W'({b.hi, b.lo}) << sh) | RAW_W'(k & ~src_mask(g));
    endfunction

endpackage

// File: rtl/chr_bank_regs.sv
module chr_bank_regs
    import chr_xlate_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [HALF_W-1:0] wr_data_i,
    output bank_reg_t         regs_o [WIN_N],
    output gran_e             gran_o
);

    bank_reg_t        regs_q [WIN_N];
    gran_e            gran_q;
    logic             lo_hit, hi_hit, ctrl_hit;
    logic [WIN_W-1:0] idx;

    assign idx      = wr_addr_i[WIN_W-1:0];
    assign lo_hit   = wr_en_i && (wr_addr_i[ADDR_W-1:WIN_W] == LO_BASE[ADDR_W-1:WIN_W]);
    assign hi_hit   = wr_en_i && (wr_addr_i[ADDR_W-1:WIN_W] == HI_BASE[ADDR_W-1:WIN_W]);
    assign ctrl_hit = wr_en_i && (wr_addr_i == CTRL_ADDR);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int i = 0; i < WIN_N; i++) begin
                regs_q[i].lo <= HALF_W'(i);
                regs_q[i].hi <= '0;
            end
            gran_q <= GRAN_8K;
        end else begin
            if (lo_hit)   regs_q[idx].lo <= wr_data_i;
            if (hi_hit)   regs_q[idx].hi <= wr_data_i;
            if (ctrl_hit) gran_q <= gran_e'(wr_data_i[4:3]);
        end
    end

    assign regs_o = regs_q;
    assign gran_o = gran_q;

    for (genvar i = 0; i < WIN_N; i++) begin : g_chk
        // R1: the first cycle out of reset shows the reset pattern
        assert_reset_pattern_R1: assert property (@(posedge clk_i) disable iff (rst_i)
            $fell(rst_i) |-> (regs_q[i].lo == HALF_W'(i) && regs_q[i].hi == '0));
        // R10: no strobe, no change
        assert_hold_idle_R10: assert property (@(posedge clk_i) disable iff (rst_i)
            !wr_en_i |=> $stable(regs_q[i]));
    end

    assert_low_load_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        lo_hit |=> regs_q[$past(idx)].lo == $past(wr_data_i));
    assert_high_load_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        hi_hit |=> regs_q[$past(idx)].hi == $past(wr_data_i));
    assert_gran_load_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        ctrl_hit |=> gran_q == gran_e'($past(wr_data_i[4:3])));
    assert_gran_hold_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        !ctrl_hit |=> $stable(gran_q));

endmodule

// File: rtl/chr_page_select.sv
module chr_page_select
    import chr_xlate_pkg::*;
(
    input  bank_reg_t         regs_i [WIN_N],
    input  gran_e             gran_i,
    input  logic [WIN_W-1:0]  win_i,
    output logic [RAW_W-1:0]  raw_o
);

    logic [RAW_W-1:0] win_raw [WIN_N];

    for (genvar k = 0; k < WIN_N; k++) begin : g_win
        logic [WIN_W-1:0] src;
        assign src        = WIN_W'(k) & src_mask(gran_i);
        assign win_raw[k] = scale(regs_i[src], gran_i, WIN_W'(k));
    end

    assign raw_o = win_raw[win_i];

endmodule

// File: rtl/chr_page_reduce.sv
module chr_page_reduce
    import chr_xlate_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [RAW_W-1:0] raw_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [CNT_W-1:0] page_o
);

    always_comb begin
        if (count_i == '0) page_o = '0;
        else               page_o = CNT_W'(raw_i % RAW_W'(count_i));
    end

endmodule

// File: rtl/chr_bank_xlate.sv
module chr_bank_xlate
    import chr_xlate_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [15:0]       wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic [CNT_W-1:0]  page_count_i,
    input  logic [12:0]       vaddr_i,
    output logic [CNT_W-1:0]  page_o,
    output logic [9:0]        offset_o
);

    bank_reg_t        regs [WIN_N];
    gran_e            gran;
    vaddr_t           va;
    logic [RAW_W-1:0] raw;

    assign va = vaddr_t'(vaddr_i);

    chr_bank_regs u_regs (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .regs_o    (regs),
        .gran_o    (gran)
    );

    chr_page_select u_sel (
        .regs_i (regs),
        .gran_i (gran),
        .win_i  (va.win),
        .raw_o  (raw)
    );

    chr_page_reduce #(.CNT_W(CNT_W)) u_red (
        .raw_i   (raw),
        .count_i (page_count_i),
        .page_o  (page_o)
    );

    assign offset_o = va.ofs;

    // R8: a nonzero page count bounds every output page
    assert_page_in_range_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (page_count_i != '0) |-> (page_o < page_count_i));

endmodule

// File: tb/chr_bank_xlate_tb.sv
module chr_bank_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] count = 16'd64;
    logic [12:0] vaddr = '0;
    logic [15:0] page;
    logic [9:0]  offset;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    int cyc = 0;

    int lo_m [8];
    int hi_m [8];
    int mode_m;

    always #5 clk = ~clk;

    chr_bank_xlate dut_i (
        .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .page_count_i(count), .vaddr_i(vaddr),
        .page_o(page), .offset_o(offset)
    );

    function automatic int bank(int i);
        return hi_m[i] * 256 + lo_m[i];
    endfunction

    function automatic int expect_page(int w);
        int raw;
        case (mode_m)
            0: raw = bank(0) * 8 + w;
            1: raw = (w < 4) ? bank(0) * 4 + w : bank(4) * 4 + (w - 4);
            2: raw = bank((w / 2) * 2) * 2 + (w % 2);
            default: raw = bank(w);
        endcase
        if (count == 0) return 0;
        return raw % int'(count);
    endfunction

    function automatic string mode_tag();
        case (mode_m)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin
            lo_m[i] = i;
            hi_m[i] = 0;
        end
        mode_m = 0;
    endtask

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        if (a >= 16'h9000 && a <= 16'h9007) lo_m[a - 16'h9000] = d;
        else if (a >= 16'hA000 && a <= 16'hA007) hi_m[a - 16'hA000] = d;
        else if (a == 16'hD000) mode_m = (d >> 3) & 3;
    endtask

    // One clock: drive at the falling edge, compare, then account for the coming edge.
    task automatic step(input logic we, input logic [15:0] a, input logic [7:0] d,
                        input int w, input string tag);
        int ep;
        int eo;
        @(negedge clk);
        wr_en = we;
        wr_addr = a;
        wr_data = d;
        eo = (w * 97 + cyc * 13) % 1024;
        vaddr = {3'(w), 10'(eo)};
        cyc++;
        #1;
        if (!rst) begin
            ep = expect_page(w);
            checks++;
            if (int'(page) != ep) begin
                failures++;
                $display("FAIL %s/%s%s win=%0d page actual=%0d expected=%0d",
                         tag, mode_tag(), (count < 16'd64) ? "/R8" : "", w, page, ep);
            end
            checks++;
            if (int'(offset) != eo) begin
                failures++;
                $display("FAIL R9 offset actual=%0d expected=%0d", offset, eo);
            end
        end
        if (rst) model_reset();
        else if (we) model_write(a, d);
    endtask

    task automatic sweep(input string tag);
        for (int w = 0; w < 8; w++) step(1'b0, 16'h0000, 8'h00, w, tag);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
        step(1'b1, a, d, cyc % 8, tag);
    endtask

    initial begin
        model_reset();
        rst = 1'b1;
        for (int i = 0; i < 3; i++) step(1'b0, 16'h0, 8'h0, i, "R1");
        rst = 1'b0;
        // r1_ reset pattern seen through all windows in 8 KB mode
        sweep("R1");

        // R2: load both register files with distinct values
        for (int i = 0; i < 8; i++) begin
            wr(16'h9000 + 16'(i), 8'((i * 37 + 5) & 255), "R2");
            wr(16'hA000 + 16'(i), 8'((i * 3 + 1) & 255), "R2");
        end
        count = 16'd65535;
        wr(16'hD000, 8'h18, "R3");
        sweep("R7");
        wr(16'hD000, 8'hE8, "R3");       // stray bits set, field = 1
        sweep("R5");
        wr(16'hD000, 8'h17, "R3");       // field = 2
        sweep("R6");
        wr(16'hD000, 8'h00, "R3");
        sweep("R4");

        // R8: fold into small and zero page counts
        foreach (count_set[j]) begin
            count = count_set[j];
            wr(16'hD000, 8'h18, "R8");
            sweep("R8");
            wr(16'hD000, 8'h08, "R8");
            sweep("R8");
        end

        // R10: near-miss addresses and suppressed strobe
        count = 16'd40000;
        wr(16'hD000, 8'h18, "R10");
        wr(16'h9008, 8'hFF, "R10");
        wr(16'hA00F, 8'hFF, "R10");
        wr(16'hD001, 8'h00, "R10");
        wr(16'h8000, 8'h55, "R10");
        wr(16'h1000, 8'h66, "R10");
        step(1'b0, 16'h9003, 8'hAA, 3, "R10");
        step(1'b0, 16'hD000, 8'h00, 1, "R10");
        sweep("R10");

        // R9: a write is visible on the very next cycle
        wr(16'h9005, 8'h21, "R9");
        step(1'b0, 16'h0, 8'h0, 5, "R9");
        wr(16'hA005, 8'h02, "R9");
        step(1'b0, 16'h0, 8'h0, 5, "R9");

        // R1: reset again restores the pattern
        rst = 1'b1;
        step(1'b0, 16'h0, 8'h0, 0, "R1");
        rst = 1'b0;
        count = 16'd64;
        sweep("R1");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    logic [15:0] count_set [4] = '{16'd24, 16'd7, 16'd1, 16'd0};

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule